// File: doc/BRIEF.md
# Strap-Sampled Mode Latch with External Interrupt Front End

The block owns four active-low input pins that do two jobs. While the chip's synchronous reset is held, the pins act as board straps: the block keeps loading their complemented, synchronized levels into a 4-bit operating-mode register. When reset drops, that register freezes. It is never sampled again.

From then on the same pins are external interrupt request lines. Each line passes through a two-flop synchronizer. Each line can be set to level-sensitive or falling-edge operation, and each can be enabled or masked on its own. Edge events sit in a per-line pending flag until software or the core acknowledges them. The block drives:

- the enabled requests,
- a wake pulse that ends a core wait state,
- a stop-exit signal that only line A can raise.

Prioritising the requests and fetching vectors are left to the block that consumes the request vector.

Top module: `strap_irq_frontend`

## Requirements
- R1: `op_mode` takes bit i from line i, with line A as bit 0 and line D as bit 3. Each bit is the complement of the pin level. While `rst` is high, the register loads every cycle from the synchronized pins. From the first cycle with `rst` low, it holds the value from the last reset cycle, whatever the pins do afterwards.
- R2: Each pin passes through two flip-flops before any logic uses it. A pin that goes low before clock edge k shows up as a level request after edge k+1.
- R3: When `cfg_edge[i]`=0 (level mode) and the line is enabled, `irq_req[i]` is high exactly while the synchronized pin is low. It drops after the second edge following the pin's return high. `ack[i]` has no effect in this mode.
- R4: When `cfg_edge[i]`=1 (falling-edge mode), a high-to-low transition on the synchronized pin sets a pending flag. The flag is seen on `irq_req[i]` after edge k+2 for a pin that fell before edge k. It stays set after the pin returns high.
- R5: `ack[i]` high at a clock edge clears line i's pending flag. If a new falling edge is detected at that same edge, the flag stays set.
- R6: A line held low in edge mode produces one event only. After it is acknowledged it stays clear until the pin rises and falls again.
- R7: `irq_en[i]`=0 forces `irq_req[i]` low and keeps line i from waking the core. Edge events are still recorded, so setting the enable later raises `irq_req[i]` at once.
- R8: `wake` is high whenever any bit of `irq_req` is high, and low otherwise.
- R9: `stop_exit` is high when `in_stop` is high and line A's synchronized pin is low. This holds regardless of line A's mode or enable. Lines B to D never drive it.
- R10: While `rst` is high, `irq_req`, `wake` and `stop_exit` are low and all pending flags are cleared. A pin that fell during reset and is still low after release creates no edge event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; strap sampling window |
| req_n_pin | input | 4 | Active-low strap / request pins, bit 0 = line A |
| cfg_edge | input | 4 | Per-line trigger select: 1 falling edge, 0 level |
| irq_en | input | 4 | Per-line enable (0 = masked) |
| ack | input | 4 | Per-line acknowledge of an edge-pending request |
| in_stop | input | 1 | Core is in the stop standby state |
| op_mode | output | 4 | Operating mode captured at reset release |
| irq_req | output | 4 | Enabled pending requests |
| wake | output | 1 | Ends a core wait state |
| stop_exit | output | 1 | Requests exit from stop, line A only |

## Verification
The properties assume the pins are driven with known levels from time zero, including the reset window. This matters because the synchronizer and delay flops are not reset, and their two-cycle history feeds the level-follow and stop-exit checks. They also assume `cfg_edge` stays put while a line holds pending state, so that pending flags and level requests are never mixed mid-event. The stimulus drives every input on the falling clock edge, holds straps steady for several cycles before reset drops, and keeps the trigger configuration fixed for the whole run. Only the enables and acknowledges move.

// File: rtl/strap_irq_pkg.sv
package strap_irq_pkg;

    localparam int unsigned NUM_LINES   = 4;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_e;

    // Per-line observation of the synchronized pin
    typedef struct packed {
        logic active;  // pin currently asserted (low)
        logic fell;    // asserted now, not asserted one cycle ago
    } line_obs_t;

    // Strap decoding: asserted (low) pin reads as a 1 bit
    function automatic logic [NUM_LINES-1:0] strap_decode(
        input logic [NUM_LINES-1:0] pin_lvl
    );
        return ~pin_lvl;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned STAGES = strap_irq_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] stg;

    // Free-running so straps are visible during reset
    always_ff @(posedge clk) begin
        stg <= {stg[LAST-1:0], d};
    end

    assign q = stg[LAST];
endmodule

// File: rtl/irq_line_ctl.sv
module irq_line_ctl
    import strap_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_n_sync,
    input  trig_e trig,
    input  logic  en,
    input  logic  ack,
    output logic  req
);
    line_obs_t obs;
    logic      act_d1;
    logic      pend_q;
    logic      raw_req;

    // Delay flop tracks through reset so a strap held low gives no edge
    always_ff @(posedge clk) begin
        act_d1 <= obs.active;
    end

    always_comb begin
        obs.active = ~pin_n_sync;
        obs.fell   = obs.active & ~act_d1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (trig == TRIG_FALL) begin
            if (obs.fell)
                pend_q <= 1'b1;      // new event beats acknowledge
            else if (ack)
                pend_q <= 1'b0;
        end else begin
            pend_q <= 1'b0;
        end
    end

    always_comb begin
        raw_req = (trig == TRIG_FALL) ? pend_q : obs.active;
        req     = raw_req & en & ~rst;
    end
endmodule

// File: rtl/mode_capture.sv
module mode_capture
    import strap_irq_pkg::*;
#(
    parameter int unsigned N_LINES = NUM_LINES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] pin_n_sync,
    output logic [N_LINES-1:0] mode
);
    // Loads throughout reset, frozen once reset drops
    always_ff @(posedge clk) begin
        if (rst)
            mode <= strap_decode(pin_n_sync);
    end
endmodule

// File: rtl/strap_irq_frontend.sv
module strap_irq_frontend
    import strap_irq_pkg::*;
#(
    parameter int unsigned N_LINES = NUM_LINES,
    parameter int unsigned N_SYNC  = SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] req_n_pin,
    input  logic [N_LINES-1:0] cfg_edge,
    input  logic [N_LINES-1:0] irq_en,
    input  logic [N_LINES-1:0] ack,
    input  logic               in_stop,
    output logic [N_LINES-1:0] op_mode,
    output logic [N_LINES-1:0] irq_req,
    output logic               wake,
    output logic               stop_exit
);
    localparam int unsigned STOP_LINE = 0;

    logic [N_LINES-1:0] pin_n_sync;

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        irq_sync #(.STAGES(N_SYNC)) u_sync (
            .clk (clk),
            .d   (req_n_pin[i]),
            .q   (pin_n_sync[i])
        );

        irq_line_ctl u_ctl (
            .clk        (clk),
            .rst        (rst),
            .pin_n_sync (pin_n_sync[i]),
            .trig       (trig_e'(cfg_edge[i])),
            .en         (irq_en[i]),
            .ack        (ack[i]),
            .req        (irq_req[i])
        );
    end

    mode_capture #(.N_LINES(N_LINES)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .pin_n_sync (pin_n_sync),
        .mode       (op_mode)
    );

    assign wake      = |irq_req;
    assign stop_exit = in_stop & ~pin_n_sync[STOP_LINE] & ~rst;
endmodule

// File: rtl/strap_irq_frontend_chk.sv
module strap_irq_frontend_chk #(
    parameter int unsigned N_LINES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [N_LINES-1:0] req_n_pin,
    input logic [N_LINES-1:0] cfg_edge,
    input logic [N_LINES-1:0] irq_en,
    input logic [N_LINES-1:0] ack,
    input logic               in_stop,
    input logic [N_LINES-1:0] op_mode,
    input logic [N_LINES-1:0] irq_req,
    input logic               wake,
    input logic               stop_exit
);
    // R1: register frozen outside the reset window
    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(op_mode));

    // R10: outputs quiet while reset is held
    p_quiet_reset_r10: assert property (@(posedge clk)
        rst |-> (irq_req == '0 && !wake && !stop_exit));

    // R7: masked lines never request
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_req & ~irq_en) == '0);

    // R8: wake present whenever a request is
    p_wake_any_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_req != '0) |-> wake);

    // R9: stop exit needs stop state and line A low two samples back
    p_stop_src_r9: assert property (@(posedge clk) disable iff (rst)
        stop_exit |-> (in_stop && !$past(req_n_pin[0], 2)));

    for (genvar i = 0; i < N_LINES; i++) begin : g_chk
        // R3: level mode follows the pin with two-flop latency
        p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
            (!cfg_edge[i] && irq_en[i] && !$past(rst, 2))
                |-> (irq_req[i] == !$past(req_n_pin[i], 2)));

        // R4: an enabled edge request persists until acknowledged
        p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(irq_req[i]) && $past(cfg_edge[i]) &&
             cfg_edge[i] && $past(irq_en[i]) && irq_en[i] && !$past(ack[i]))
                |-> irq_req[i]);
    end
endmodule

bind strap_irq_frontend strap_irq_frontend_chk #(.N_LINES(N_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_n_pin (req_n_pin),
    .cfg_edge  (cfg_edge),
    .irq_en    (irq_en),
    .ack       (ack),
    .in_stop   (in_stop),
    .op_mode   (op_mode),
    .irq_req   (irq_req),
    .wake      (wake),
    .stop_exit (stop_exit)
);

// File: tb/strap_irq_frontend_bench.sv
module strap_irq_frontend_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req_n_pin = 4'b1111;
    logic [3:0] cfg_edge  = 4'b0010;   // line B falling-edge, others level
    logic [3:0] irq_en    = 4'b1111;
    logic [3:0] ack       = 4'b0000;
    logic       in_stop   = 1'b1;
    logic [3:0] op_mode;
    logic [3:0] irq_req;
    logic       wake;
    logic       stop_exit;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    strap_irq_frontend u_strap_irq_frontend (
        .clk       (clk),
        .rst       (rst),
        .req_n_pin (req_n_pin),
        .cfg_edge  (cfg_edge),
        .irq_en    (irq_en),
        .ack       (ack),
        .in_stop   (in_stop),
        .op_mode   (op_mode),
        .irq_req   (irq_req),
        .wake      (wake),
        .stop_exit (stop_exit)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {pins, ack, in_stop, exp_irq, exp_wake, exp_stop}; one row per cycle
    localparam int NV = 12;
    localparam logic [14:0] VEC [NV] = '{
        {4'b1110, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0},  // R2 first flop only
        {4'b1110, 4'b0000, 1'b0, 4'b0001, 1'b1, 1'b0},  // R2 A level seen
        {4'b1100, 4'b0000, 1'b0, 4'b0001, 1'b1, 1'b0},
        {4'b1100, 4'b0000, 1'b0, 4'b0001, 1'b1, 1'b0},  // R4 edge detected, not yet pending
        {4'b1111, 4'b0000, 1'b0, 4'b0011, 1'b1, 1'b0},  // R4 B pending
        {4'b1111, 4'b0000, 1'b0, 4'b0010, 1'b1, 1'b0},  // R4 B held after pin high
        {4'b1111, 4'b0010, 1'b0, 4'b0000, 1'b0, 1'b0},  // R5 ack clears, R8 wake low
        {4'b1111, 4'b0000, 1'b1, 4'b0000, 1'b0, 1'b0},  // R9 A high, no exit
        {4'b1110, 4'b0000, 1'b1, 4'b0000, 1'b0, 1'b0},
        {4'b1110, 4'b0000, 1'b1, 4'b0001, 1'b1, 1'b1},  // R9 stop exit
        {4'b1111, 4'b0000, 1'b0, 4'b0001, 1'b1, 1'b0},  // R9 needs in_stop
        {4'b1111, 4'b0000, 1'b0, 4'b0000, 1'b0, 1'b0}
    };

    initial begin
        // Reset window; B falls during reset, A low as strap
        step(3);
        req_n_pin = 4'b1000;
        step(4);
        chk("R1 strap load", {4'b0, op_mode}, 8'h07);
        chk("R10 irq in reset", {4'b0, irq_req}, 8'h00);
        chk("R10 wake/stop in reset", {6'b0, wake, stop_exit}, 8'h00);
        rst = 1'b0;
        step(1);
        chk("R9 stop exit after release", {7'b0, stop_exit}, 8'h01);
        chk("R10 no edge from reset-time fall", {4'b0, irq_req}, 8'h05);
        in_stop   = 1'b0;
        req_n_pin = 4'b1111;
        step(4);
        chk("R1 frozen after release", {4'b0, op_mode}, 8'h07);
        chk("R3 idle", {4'b0, irq_req}, 8'h00);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            req_n_pin = VEC[v][14:11];
            ack       = VEC[v][10:7];
            in_stop   = VEC[v][6];
            step(1);
            chk($sformatf("R2/R4/R5/R9 vec %0d irq", v), {4'b0, irq_req}, {4'b0, VEC[v][5:2]});
            chk($sformatf("R8 vec %0d wake", v), {7'b0, wake}, {7'b0, VEC[v][1]});
            chk($sformatf("R9 vec %0d stop", v), {7'b0, stop_exit}, {7'b0, VEC[v][0]});
        end
        ack = 4'b0000;
        in_stop = 1'b0;
        step(2);

        // R7: masked edge line records but stays silent
        irq_en    = 4'b1101;
        req_n_pin = 4'b1101;
        step(3);
        req_n_pin = 4'b1111;
        step(3);
        chk("R7 masked irq", {4'b0, irq_req}, 8'h00);
        chk("R7 masked wake", {7'b0, wake}, 8'h00);
        chk("R1 still frozen", {4'b0, op_mode}, 8'h07);
        irq_en = 4'b1111;
        #1;
        chk("R7 recorded edge on enable", {4'b0, irq_req}, 8'h02);
        chk("R8 wake on enable", {7'b0, wake}, 8'h01);

        // R5: ack coinciding with new edge keeps pending
        step(1);
        req_n_pin = 4'b1101;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        ack = 4'b0010;
        step(1);
        ack = 4'b0000;
        chk("R5 set beats ack", {7'b0, irq_req[1]}, 8'h01);

        // R6: held low, one event only
        ack = 4'b0010;
        step(1);
        ack = 4'b0000;
        chk("R6 ack clears held line", {7'b0, irq_req[1]}, 8'h00);
        step(3);
        chk("R6 no re-trigger while low", {7'b0, irq_req[1]}, 8'h00);
        req_n_pin = 4'b1111;
        step(3);

        // R3: level mode ignores ack, drops two edges after release
        req_n_pin = 4'b1110;
        step(3);
        ack = 4'b0001;
        step(1);
        ack = 4'b0000;
        chk("R3 ack ignored in level", {4'b0, irq_req}, 8'h01);
        req_n_pin = 4'b1111;
        step(1);
        chk("R3 still held one edge later", {4'b0, irq_req}, 8'h01);
        step(1);
        chk("R3 released after two edges", {4'b0, irq_req}, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule